// File: doc/BRIEF.md
# Forwarded-Clock 10:1 Serial Lane Deserializer

This block turns one single-ended serial data lane into 10-bit parallel words. The lane comes with a slow forwarded frame clock that runs at one tenth of the bit rate. A local capture clock runs at half the bit rate and has already been phase-shifted so that its edges sit in the middle of the data eye. The block samples the data on both edges of this capture clock. The bit taken on the rising edge is the earlier bit of each pair.

The frame-clock level is also sampled on the rising capture edge. A low-to-high change of that level marks the first pair of a new word. Five pairs later the word is complete, and it is pushed into a small asynchronous FIFO with Gray-coded pointers. The FIFO carries the word into the shared system clock domain, where it appears for one cycle with a valid strobe. Each lane from an independent sender gets its own instance, and all instances deliver into the same system clock.

Word delivery starts only once the frame edges have proved periodic. Misplaced frame edges raise a sticky alignment flag. Words that find the FIFO full are discarded and raise a sticky overflow flag.

Top module: `lane_deser10`

## Requirements
- R1: The rising-edge sample of each capture-clock cycle is the earlier bit of a pair. The first bit of a frame lands in word bit 9, and later bits fill lower positions in arrival order.
- R2: A pair whose sampled frame level is 1 while the previous pair's level was 0 holds word bits 9 and 8. This holds however many pairs the frame level then stays high.
- R3: Every complete, locked frame of five pairs yields exactly one word in the system domain, and words arrive in the order sent.
- R4: After reset, no word is delivered until a frame edge has arrived exactly 10 bits (5 pairs) after the previous frame edge. The first frame after reset is therefore never delivered.
- R5: A frame edge that arrives at any spacing other than 10 bits sets align_err_o, which stays set until reset. The frame that edge starts is not delivered. The bit count restarts at that edge, so the next frame at correct spacing is delivered again.
- R6: A frame cut short by an early frame edge is never delivered.
- R7: The crossing holds 4 words. A word completed while 4 words are waiting is discarded, and ovf_o is set and stays set until reset. The stored words are still delivered in order.
- R8: valid_o is high for one system cycle per delivered word. word_o keeps the last delivered word while valid_o is low.
- R9: While reset is held, valid_o, align_err_o and ovf_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Phase-centred capture clock at half the bit rate |
| fast_rst_n | input | 1 | Active-low asynchronous reset, capture domain |
| ser_i | input | 1 | Serial data, sampled on both edges of fast_clk |
| frm_i | input | 1 | Frame-clock level, sampled on the rising edge of fast_clk |
| sys_clk | input | 1 | Common system clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| word_o | output | 10 | Delivered word, first received bit in bit 9 |
| valid_o | output | 1 | One-cycle strobe for word_o (system domain) |
| align_err_o | output | 1 | Sticky frame-spacing error (capture domain) |
| ovf_o | output | 1 | Sticky word-dropped flag (capture domain) |

## Verification
The last pair of a frame is sampled on a rising and a falling capture edge. The framer registers the completed word on the next rising edge, and the FIFO write lands one capture cycle after that. The write pointer then passes two system flops, and one more system edge raises valid_o. That makes roughly two capture cycles plus three system cycles from the last bit to the strobe. The two clocks are unrelated, so the bench does not predict the exact system cycle. Instead, its pair-level model queues each expected word at send time, and on every system falling edge any strobe is compared with the head of that queue. The flags are set one capture edge after the offending pair, and the bench reads them only after at least one more full frame or idle gap has been sent.

// File: rtl/lane_deser_pkg.sv
package lane_deser_pkg;

    // Lock tracking of the frame-edge sequence.
    typedef enum logic [1:0] {
        SYNC_HUNT   = 2'd0,  // no frame edge seen since reset
        SYNC_ARMED  = 2'd1,  // one edge seen, spacing not yet proven
        SYNC_LOCKED = 2'd2   // last edge came exactly one word after the one before
    } lane_sync_e;

    function automatic logic [7:0] bin_to_gray8(input logic [7:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/lane_ddr_capture.sv
module lane_ddr_capture (
    input  logic fast_clk,
    input  logic fast_rst_n,
    input  logic ser_i,
    input  logic frm_i,
    output logic early_o,
    output logic late_o,
    output logic frm_o
);
    logic early_q, frm_q, late_q;

    // Rising-edge samples: earlier bit of the pair and the frame level.
    always_ff @(posedge fast_clk or negedge fast_rst_n) begin
        if (!fast_rst_n) begin
            early_q <= 1'b0;
            frm_q   <= 1'b0;
        end else begin
            early_q <= ser_i;
            frm_q   <= frm_i;
        end
    end

    // Falling-edge sample: later bit of the pair.
    always_ff @(negedge fast_clk or negedge fast_rst_n) begin
        if (!fast_rst_n) late_q <= 1'b0;
        else             late_q <= ser_i;
    end

    assign early_o = early_q;
    assign late_o  = late_q;
    assign frm_o   = frm_q;
endmodule

// File: rtl/lane_framer.sv
module lane_framer #(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_early,
    input  logic              bit_late,
    input  logic              frm_lvl,
    output logic              push_o,
    output logic [WORD_W-1:0] word_o,
    output logic              align_err_o
);
    import lane_deser_pkg::*;

    localparam int unsigned PAIRS = WORD_W / 2;
    localparam int unsigned CNT_W = $clog2(PAIRS) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAIRS - 1);
    localparam logic [CNT_W-1:0] CNT_PREV = CNT_W'(PAIRS - 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    typedef struct packed {
        logic              frm_prev;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        lane_sync_e        sync;
        logic              push;
        logic [WORD_W-1:0] word;
        logic              err;
    } framer_t;

    localparam framer_t FR_RST = '{
        frm_prev: 1'b0, cnt: CNT_SAT, sh: '0, sync: SYNC_HUNT,
        push: 1'b0, word: '0, err: 1'b0
    };

    framer_t s_q, s_d;
    logic    frame_edge, spacing_ok;
    logic [WORD_W-1:0] sh_next;

    always_comb begin
        s_d        = s_q;
        s_d.push   = 1'b0;
        frame_edge = frm_lvl & ~s_q.frm_prev;
        spacing_ok = (s_q.cnt == CNT_LAST);
        sh_next    = {s_q.sh[WORD_W-3:0], bit_early, bit_late};
        s_d.frm_prev = frm_lvl;
        s_d.sh       = sh_next;
        if (frame_edge) begin
            s_d.cnt = '0;
            if (s_q.sync == SYNC_HUNT) begin
                s_d.sync = SYNC_ARMED;
            end else if (spacing_ok) begin
                s_d.sync = SYNC_LOCKED;
            end else begin
                s_d.sync = SYNC_ARMED;
                s_d.err  = 1'b1;
            end
        end else begin
            if (s_q.cnt != CNT_SAT) s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.sync == SYNC_LOCKED && s_q.cnt == CNT_PREV) begin
                s_d.push = 1'b1;
                s_d.word = sh_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= FR_RST;
        else        s_q <= s_d;
    end

    assign push_o      = s_q.push;
    assign word_o      = s_q.word;
    assign align_err_o = s_q.err;

    // R3: a word takes five pairs, so two pushes never come back to back.
    assert_push_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.push |=> !s_q.push);
    // R4: words are only pushed while the edge sequence is locked.
    assert_push_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.push |-> (s_q.sync == SYNC_LOCKED));
    // R5: the alignment flag is sticky.
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |=> s_q.err);
endmodule

// File: rtl/lane_sync2.sv
module lane_sync2 #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/lane_xfifo.sv
module lane_xfifo #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ovf_o,
    input  logic              rclk,
    input  logic              rrst_n,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    import lane_deser_pkg::*;

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ovf;
    } wr_t;

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    wr_t w_q, w_d;
    rd_t r_q, r_d;
    logic [PW-1:0] rgray_ws, wgray_rs;
    logic full_w, empty_w, wr_fire;

    lane_sync2 #(.W(PW)) u_rptr_sync (
        .clk(wclk), .rst_n(wrst_n), .d_i(r_q.gray), .q_o(rgray_ws));
    lane_sync2 #(.W(PW)) u_wptr_sync (
        .clk(rclk), .rst_n(rrst_n), .d_i(w_q.gray), .q_o(wgray_rs));

    // Write side, capture domain.
    always_comb begin
        w_d     = w_q;
        full_w  = (w_q.gray == {~rgray_ws[PW-1:PW-2], rgray_ws[PW-3:0]});
        wr_fire = push_i & ~full_w;
        if (wr_fire) begin
            w_d.bin  = w_q.bin + 1'b1;
            w_d.gray = PW'(bin_to_gray8(8'(w_d.bin)));
        end
        if (push_i & full_w) w_d.ovf = 1'b1;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (wr_fire) mem_q[w_q.bin[AW-1:0]] <= data_i;
    end

    // Read side, system domain: pop whenever a word is waiting.
    always_comb begin
        r_d       = r_q;
        empty_w   = (r_q.gray == wgray_rs);
        r_d.valid = ~empty_w;
        if (!empty_w) begin
            r_d.data = mem_q[r_q.bin[AW-1:0]];
            r_d.bin  = r_q.bin + 1'b1;
            r_d.gray = PW'(bin_to_gray8(8'(r_d.bin)));
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign ovf_o   = w_q.ovf;
    assign data_o  = r_q.data;
    assign valid_o = r_q.valid;

    // R7: write pointer moves by one Gray step at most.
    assert_wgray_step_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(w_q.gray ^ $past(w_q.gray)) <= 1);
    // R7: a push against a full buffer leaves the overflow flag set.
    assert_drop_flags_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
        (push_i && full_w) |=> w_q.ovf);
    // R7: overflow is sticky.
    assert_ovf_sticky_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
        w_q.ovf |=> w_q.ovf);
    // R8: read pointer moves by one Gray step at most.
    assert_rgray_step_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(r_q.gray ^ $past(r_q.gray)) <= 1);
    // R8: data holds whenever no word is delivered.
    assert_data_hold_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
        !r_q.valid |-> $stable(r_q.data) || $past(r_q.valid) || $past(!empty_w));
endmodule

// File: rtl/lane_deser10.sv
module lane_deser10 #(
    parameter int unsigned WORD_W     = 10,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              fast_clk,
    input  logic              fast_rst_n,
    input  logic              ser_i,
    input  logic              frm_i,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              align_err_o,
    output logic              ovf_o
);
    logic              early_w, late_w, frm_w;
    logic              push_w;
    logic [WORD_W-1:0] fword_w;

    lane_ddr_capture u_cap (
        .fast_clk   (fast_clk),
        .fast_rst_n (fast_rst_n),
        .ser_i      (ser_i),
        .frm_i      (frm_i),
        .early_o    (early_w),
        .late_o     (late_w),
        .frm_o      (frm_w)
    );

    lane_framer #(.WORD_W(WORD_W)) u_frm (
        .clk         (fast_clk),
        .rst_n       (fast_rst_n),
        .bit_early   (early_w),
        .bit_late    (late_w),
        .frm_lvl     (frm_w),
        .push_o      (push_w),
        .word_o      (fword_w),
        .align_err_o (align_err_o)
    );

    lane_xfifo #(.DATA_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_xf (
        .wclk    (fast_clk),
        .wrst_n  (fast_rst_n),
        .push_i  (push_w),
        .data_i  (fword_w),
        .ovf_o   (ovf_o),
        .rclk    (sys_clk),
        .rrst_n  (sys_rst_n),
        .data_o  (word_o),
        .valid_o (valid_o)
    );
endmodule

// File: tb/tb_lane_deser10.sv
`timescale 1ns/100ps
module tb_lane_deser10;
    logic fast_clk = 1'b0, sys_clk = 1'b0;
    logic fast_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic ser_i = 1'b0, frm_i = 1'b0;
    logic [9:0] word_o;
    logic valid_o, align_err_o, ovf_o;
    bit sys_run = 1'b1;
    bit done = 1'b0;

    int checks = 0, failures = 0;

    // Pair-level behavioural model state.
    bit m_prev = 0, m_have = 0, m_lock = 0;
    int m_since = 0, m_acc = 0, m_stalled = 0;
    bit exp_err = 0, exp_ovf = 0;
    logic [9:0] expq [$];
    bit have_last = 0;
    logic [9:0] last_word = '0;

    lane_deser10 dut (
        .fast_clk(fast_clk), .fast_rst_n(fast_rst_n), .ser_i(ser_i), .frm_i(frm_i),
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .word_o(word_o), .valid_o(valid_o),
        .align_err_o(align_err_o), .ovf_o(ovf_o)
    );

    always #5 fast_clk = ~fast_clk;
    always begin
        #3;
        if (sys_run) sys_clk = ~sys_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic void deliver(input logic [9:0] w);
        if (!sys_run) begin
            if (m_stalled < 4) begin
                expq.push_back(w);
                m_stalled++;
            end else begin
                exp_ovf = 1'b1;
            end
        end else begin
            expq.push_back(w);
        end
    endfunction

    function automatic void model_pair(input bit a, input bit b, input bit f);
        if (f && !m_prev) begin
            if (m_have && m_since == 5) m_lock = 1'b1;
            else begin
                if (m_have) exp_err = 1'b1;
                m_lock = 1'b0;
            end
            m_have  = 1'b1;
            m_since = 1;
            m_acc   = int'({a, b});
        end else begin
            m_since++;
            m_acc = ((m_acc << 2) | int'({a, b})) & 32'h3FF;
            if (m_lock && m_since == 5) deliver(10'(m_acc));
        end
        m_prev = f;
    endfunction

    // Rising sample taken at T+5 sees a, falling sample at T+10 sees b.
    task automatic send_pair(input bit a, input bit b, input bit f);
        @(negedge fast_clk);
        #2;
        ser_i = a;
        frm_i = f;
        #5;
        ser_i = b;
        model_pair(a, b, f);
    endtask

    task automatic send_frame(input logic [9:0] w, input int hi);
        for (int i = 0; i < 5; i++) send_pair(w[9-2*i], w[8-2*i], i < hi);
    endtask

    task automatic send_short(input logic [9:0] w, input int n);
        for (int i = 0; i < n; i++) send_pair(w[9-2*i], w[8-2*i], i < n - 1);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_pair(1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Compare every system cycle against the model queue.
    always @(negedge sys_clk) begin
        if (sys_rst_n && !done) begin
            if (valid_o) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4/R6 unexpected word", int'(word_o), 0);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    check(word_o == e, "R1/R2/R3 word", int'(word_o), int'(e));
                end
                have_last = 1'b1;
                last_word = word_o;
            end else if (have_last) begin
                check(word_o == last_word, "R8 hold", int'(word_o), int'(last_word));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        #33;
        check(valid_o == 1'b0, "R9 valid", int'(valid_o), 0);
        check(align_err_o == 1'b0, "R9 align", int'(align_err_o), 0);
        check(ovf_o == 1'b0, "R9 ovf", int'(ovf_o), 0);
        @(negedge fast_clk);
        fast_rst_n = 1'b1;
        sys_rst_n  = 1'b1;
        send_idle(3);

        // R4: first frame only arms; following frames are delivered (R1, R2, R3).
        send_frame(10'h2AA, 3);
        send_frame(10'h3FF, 3);
        send_frame(10'h000, 1);
        send_frame(10'h155, 4);
        send_frame(10'h201, 3);
        send_frame(10'h0F3, 2);
        send_frame(10'h1C7, 3);
        send_idle(4);
        check(align_err_o == exp_err, "R5 no error yet", int'(align_err_o), int'(exp_err));

        // R5: edge after a gap is misplaced; its frame is lost, next one resumes.
        send_frame(10'h111, 3);
        send_frame(10'h222, 3);
        send_frame(10'h333, 3);
        check(align_err_o == 1'b1, "R5 error set", int'(align_err_o), 1);

        // R6: truncated frame, then misplaced edge, then recovery.
        send_frame(10'h0FF, 3);
        send_short(10'h3C0, 3);
        send_frame(10'h0AA, 3);
        send_frame(10'h055, 3);
        send_idle(10);
        repeat (40) @(posedge fast_clk);
        check(expq.size() == 0, "R3 drained", expq.size(), 0);
        check(ovf_o == 1'b0, "R7 no overflow yet", int'(ovf_o), 0);

        // R7: freeze the system clock so the four-entry crossing fills.
        sys_run = 1'b0;
        #20;
        send_frame(10'h101, 3);
        send_frame(10'h102, 3);
        send_frame(10'h103, 3);
        send_frame(10'h104, 3);
        send_frame(10'h105, 3);
        send_frame(10'h106, 3);
        send_frame(10'h107, 3);
        send_idle(4);
        check(ovf_o == 1'b1, "R7 overflow set", int'(ovf_o), 1);
        check(ovf_o == exp_ovf, "R7 model agrees", int'(ovf_o), int'(exp_ovf));
        m_stalled = 0;
        sys_run = 1'b1;
        repeat (60) @(posedge fast_clk);

        check(expq.size() == 0, "R7 stored words delivered", expq.size(), 0);
        check(align_err_o == exp_err, "R5 final", int'(align_err_o), int'(exp_err));
        check(ovf_o == exp_ovf, "R7 final", int'(ovf_o), int'(exp_ovf));
        finish_run();
    end
endmodule